// File: doc/BRIEF.md
# Strand Pause Counter Unit

This block holds one hardware thread stalled for a requested number of clock cycles. Software-side logic writes a cycle amount. The unit divides that amount by eight and keeps the quotient in a pause counter. A three-bit prescaler then lets the counter step down once every eight cycles. While the count runs, the `blocked` output stays high so that a scheduler can hand the core to other threads.

An amount below eight still costs one blocked cycle. A disrupting trap ends the stall before the count finishes. When blocking ends, for either reason, `pauseDone` pulses for one cycle. The `trapAbort` status bit records whether a trap caused the end. A fresh write during a stall reloads the counter and the prescaler, so the stall restarts from the new amount.

All inputs are sampled on the rising clock edge. The trap input should therefore be synchronised by its source before it reaches this block.

Top module: `pause_unit`

## Requirements
- R1: A write (`wrEn` high at a rising edge) makes `blocked` high from the next cycle on, with the pause counter loaded with `wrData` shifted right by 3 bits.
- R2: For `wrData` of 8 or more, `blocked` stays high for exactly (`wrData` >> 3) * 8 cycles, so bits [2:0] of the amount have no effect.
- R3: For `wrData` below 8, `blocked` stays high for exactly 1 cycle.
- R4: `trapIn` high at a rising edge while `blocked` is high, with no write at the same edge, makes `blocked` low from the next cycle and sets `trapAbort` to 1.
- R5: `trapIn` while `blocked` is low has no effect: `blocked`, `pauseDone` and `trapAbort` are unchanged.
- R6: A write while `blocked` is high restarts the pause: the counter and the prescaler are reloaded, and the new amount alone sets the remaining length. A write at the same edge as a trap wins over the trap.
- R7: `pauseDone` is high for exactly one cycle, the first cycle after `blocked` falls. It does not pulse when a write restarts a pause.
- R8: `trapAbort` is 0 after a pause that ends by expiry, and every write clears it.
- R9: After reset, `blocked`, `pauseDone` and `trapAbort` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| wrEn | input | 1 | Strobe that writes a pause amount |
| wrData | input | 32 | Requested pause length in cycles |
| trapIn | input | 1 | Disrupting trap; ends an active pause |
| blocked | output | 1 | Thread is stalled |
| pauseDone | output | 1 | One-cycle pulse after a pause ends |
| trapAbort | output | 1 | Last pause ended because of a trap |

## Verification
The assertions assume that `wrEn` and `trapIn` are clean, synchronous, single-bit levels that are sampled only at rising edges. They also assume that a write lasts one cycle per request. The bench changes every input at the falling edge and holds each write for exactly one cycle. It raises traps only after the trap source has settled at that same falling edge. The bench measures stall lengths by sampling `blocked` at falling edges. A cap on each measurement bounds every wait.

// File: rtl/pause_pkg.sv
package pause_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // reload counter and prescaler from write data
    logic advance;  // step prescaler, decrement counter on its wrap
  } pauseStrobe_t;
endpackage

// File: rtl/pause_datapath.sv
module pause_datapath
  import pause_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int GRAN_SHIFT = 3,
  localparam int CNT_W = DATA_W - GRAN_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  pauseStrobe_t      strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic              endNow
);
  logic [CNT_W-1:0]      pauseCnt;
  logic [GRAN_SHIFT-1:0] prescale;
  logic                  preWrap;
  logic                  cntZero;
  logic                  cntOne;

  assign preWrap = &prescale;
  assign cntZero = (pauseCnt == '0);
  assign cntOne  = (pauseCnt == CNT_W'(1));
  // Pause ends now: request was below one granule, or last granule finishing
  assign endNow  = cntZero | (cntOne & preWrap);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pauseCnt <= '0;
      prescale <= '0;
    end else if (strobe.load) begin
      pauseCnt <= wrData[DATA_W-1:GRAN_SHIFT];
      prescale <= '0;
    end else if (strobe.advance) begin
      prescale <= prescale + 1'b1;
      if (preWrap && !cntZero) pauseCnt <= pauseCnt - 1'b1;
    end
  end

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> pauseCnt == $past(wrData[DATA_W-1:GRAN_SHIFT])); // R1
  AST_PRESCALER_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> prescale == '0); // R6
  AST_NO_COUNT_UP: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> pauseCnt <= $past(pauseCnt)); // R2
endmodule

// File: rtl/pause_control.sv
module pause_control
  import pause_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic         trapIn,
  input  logic         endNow,
  output pauseStrobe_t strobe,
  output logic         blocked,
  output logic         pauseDone,
  output logic         trapAbort
);
  always_comb begin
    strobe.load    = wrEn;
    strobe.advance = blocked & ~wrEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blocked   <= 1'b0;
      pauseDone <= 1'b0;
      trapAbort <= 1'b0;
    end else if (wrEn) begin
      blocked   <= 1'b1;
      pauseDone <= 1'b0;
      trapAbort <= 1'b0;
    end else if (blocked && trapIn) begin
      blocked   <= 1'b0;
      pauseDone <= 1'b1;
      trapAbort <= 1'b1;
    end else if (blocked && endNow) begin
      blocked   <= 1'b0;
      pauseDone <= 1'b1;
      trapAbort <= 1'b0;
    end else begin
      pauseDone <= 1'b0;
    end
  end

  AST_WRITE_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> blocked && !trapAbort); // R1
  AST_TRAP_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    blocked && trapIn && !wrEn |=> !blocked && trapAbort && pauseDone); // R4
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    !blocked && !wrEn |=> !blocked && $stable(trapAbort)); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    pauseDone |=> !pauseDone); // R7
  AST_DONE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rstN)
    pauseDone |-> !blocked && $past(blocked)); // R7
endmodule

// File: rtl/pause_unit.sv
module pause_unit
  import pause_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int GRAN_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              trapIn,
  output logic              blocked,
  output logic              pauseDone,
  output logic              trapAbort
);
  pauseStrobe_t strobe;
  logic         endNow;

  pause_control u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .trapIn(trapIn), .endNow(endNow),
    .strobe(strobe), .blocked(blocked), .pauseDone(pauseDone),
    .trapAbort(trapAbort)
  );

  pause_datapath #(.DATA_W(DATA_W), .GRAN_SHIFT(GRAN_SHIFT)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .endNow(endNow)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rstN |=> !blocked && !pauseDone && !trapAbort); // R9
endmodule

// File: tb/pause_unit_tb.sv
`timescale 1ns/1ps
module pause_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        trapIn = 1'b0;
  logic        blocked, pauseDone, trapAbort;
  int          checks = 0;
  int          fails = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  pause_unit u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .trapIn(trapIn),
    .blocked(blocked), .pauseDone(pauseDone), .trapAbort(trapAbort)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive a one-cycle write; returns at the falling edge after the write edge
  task automatic doWrite(input logic [31:0] val);
    @(negedge clk);
    wrEn = 1'b1; wrData = val;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Count falling-edge samples with blocked high; stops on first low sample
  task automatic countBlocked(output int n);
    n = 0;
    while (blocked && n < 100000) begin
      n++;
      if (pauseDone) check(0, "R7 done during pause", 1, 0);
      @(negedge clk);
    end
  endtask

  task automatic expiryCase(input logic [31:0] val, input int expLen, input string req);
    int n;
    doWrite(val);
    check(trapAbort == 1'b0, "R8 abort clear after write", int'(trapAbort), 0);
    countBlocked(n);
    check(n == expLen, req, n, expLen);
    check(pauseDone == 1'b1, "R7 done pulse", int'(pauseDone), 1);
    check(trapAbort == 1'b0, "R8 expiry no abort", int'(trapAbort), 0);
    @(negedge clk);
    check(pauseDone == 1'b0, "R7 done single cycle", int'(pauseDone), 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(!blocked && !pauseDone && !trapAbort, "R9 reset state",
          int'({blocked, pauseDone, trapAbort}), 0);
  endtask

  task automatic testSmall();
    expiryCase(32'd0, 1, "R3 zero amount");
    expiryCase(32'd7, 1, "R3 amount seven");
    expiryCase(32'd1, 1, "R3 amount one");
  endtask

  task automatic testGranules();
    expiryCase(32'd8, 8, "R2 one granule");
    expiryCase(32'd15, 8, "R2 low bits ignored");
    expiryCase(32'd40, 40, "R2 five granules");
    expiryCase(32'd805, 800, "R1 R2 hundred granules");
  endtask

  task automatic testTrap();
    doWrite(32'd800);
    check(blocked == 1'b1, "R1 blocked after write", int'(blocked), 1);
    repeat (5) @(negedge clk);
    trapIn = 1'b1;
    @(negedge clk);
    trapIn = 1'b0;
    check(blocked == 1'b0, "R4 trap ends pause", int'(blocked), 0);
    check(pauseDone == 1'b1, "R7 done on trap", int'(pauseDone), 1);
    check(trapAbort == 1'b1, "R4 abort flag", int'(trapAbort), 1);
    @(negedge clk);
    check(pauseDone == 1'b0, "R7 trap done single", int'(pauseDone), 0);
    check(trapAbort == 1'b1, "R4 abort held", int'(trapAbort), 1);
  endtask

  task automatic testIdleTrap();
    bit sawChange = 0;
    logic abortBefore;
    abortBefore = trapAbort;
    trapIn = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (blocked || pauseDone || trapAbort != abortBefore) sawChange = 1;
    end
    trapIn = 1'b0;
    check(!sawChange, "R5 idle trap ignored", int'(sawChange), 0);
    expiryCase(32'd16, 16, "R8 write clears abort then expires");
  endtask

  task automatic testRestart();
    int n;
    doWrite(32'd80);
    repeat (20) @(negedge clk);
    doWrite(32'd16);
    check(pauseDone == 1'b0 && blocked, "R6 no done on restart", int'(pauseDone), 0);
    countBlocked(n);
    check(n == 16, "R6 restart length", n, 16);
    check(pauseDone == 1'b1, "R7 done after restart", int'(pauseDone), 1);
    // write coinciding with trap: write wins
    doWrite(32'd80);
    @(negedge clk);
    wrEn = 1'b1; wrData = 32'd24; trapIn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; trapIn = 1'b0;
    check(blocked && !trapAbort, "R6 write beats trap", int'(blocked), 1);
    countBlocked(n);
    check(n == 24, "R6 reload after trap clash", n, 24);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSmall();
    testGranules();
    testTrap();
    testIdleTrap();
    testRestart();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule